// File: doc/BRIEF.md
# Configurable Port Pin Controller

This block controls an 8-bit general-purpose port. Each pin has three settings held in registers: a direction bit, a mode bit and an output data bit. Together they decide how the pin behaves. It can be a push-pull output, an open-drain output or a high-impedance input. The pin is driven either by software through the data register or by an on-chip peripheral through a pair of per-pin output-value and output-enable inputs.

Software reaches the registers over a simple register bus. A write takes effect on the clock edge that samples it. Reads are combinational from the current register contents. The level on each pin comes back through a two-flop synchronizer and can be read at all times, whatever the mode and direction. The block produces per-pin drive-value and drive-enable signals for an external pad; the pad itself and any pull-ups sit outside it.

The register bus is a control path with no flow control: every write is accepted on the cycle it is presented, and a read returns data in the same cycle. The port has no data stream, so it has no valid/ready handshake.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset the direction and data registers read 0xFF and the mode register reads 0x00, so every pin is released (pad_oe = 0, pad_out = 0).
- R2: A write with bus_wr high loads bus_wdata into the register selected by bus_addr (0 = direction, 1 = mode, 2 = data). The new value reads back from the next cycle on.
- R3: A pin with mode 0 and direction 0 is a push-pull output: pad_oe is 1 and pad_out equals its data bit.
- R4: A pin with mode 0 and direction 1 is open-drain. A data bit of 0 drives it low (pad_oe 1, pad_out 0). A data bit of 1 releases it (pad_oe 0), which makes it a high-impedance input.
- R5: A pin with mode 1, direction 0 and periph_oe 1 is a push-pull output of periph_out. Its data bit has no effect on it.
- R6: A pin with mode 1, direction 1 and periph_oe 1 is an open-drain output of the peripheral. periph_out 0 drives it low, and periph_out 1 releases it.
- R7: A pin with mode 1 and periph_oe 0 is released (pad_oe 0), whatever its direction and data bits.
- R8: Address 3 reads the pin levels. A level on pad_in becomes readable after two rising clock edges, in every configuration. Writes to address 3 have no effect on any register or pin.
- R9: pad_out is 0 on every pin whose pad_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 mode, 2 data, 3 pin levels |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 8 | Level seen on each pin |
| pad_out | output | 8 | Per-pin drive value |
| pad_oe | output | 8 | Per-pin drive enable |
| periph_out | input | 8 | Peripheral output value per pin |
| periph_oe | input | 8 | Peripheral output enable per pin |

## Verification
The assertions check on every cycle that a released pin outputs 0, that general-purpose push-pull pins are always enabled, that a special-function pin with its peripheral enable low is released, that a direction write lands, and that the readable pin state lags pad_in by exactly two edges. The bench's scenarios cover the rest: the exact drive values of each mode/direction pair, pins in mixed configurations within one byte, the reset contents, and a write to the pin address that must leave everything unchanged.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_MODE = 2'd1,
    SEL_DATA = 2'd2,
    SEL_PIN  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic [WIDTH-1:0] pin_lvl,
  output logic [WIDTH-1:0] bus_rdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] mode_q,
  output logic [WIDTH-1:0] data_q
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      mode_q <= '0;
      data_q <= '1;
    end else if (bus_wr) begin
      case (sel)
        SEL_DIR:  dir_q  <= bus_wdata;
        SEL_MODE: mode_q <= bus_wdata;
        SEL_DATA: data_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DIR:  bus_rdata = dir_q;
      SEL_MODE: bus_rdata = mode_q;
      SEL_DATA: bus_rdata = data_q;
      default:  bus_rdata = pin_lvl;
    endcase
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
  input  logic dir_b,
  input  logic mode_b,
  input  logic data_b,
  input  logic per_out,
  input  logic per_oe,
  output logic drv,
  output logic en
);
  always_comb begin
    drv = 1'b0;
    en  = 1'b0;
    if (!mode_b) begin
      if (!dir_b) begin
        en  = 1'b1;
        drv = data_b;
      end else begin
        en  = ~data_b;
      end
    end else if (per_oe) begin
      if (!dir_b) begin
        en  = 1'b1;
        drv = per_out;
      end else begin
        en  = ~per_out;
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  input  logic [WIDTH-1:0] periph_out,
  input  logic [WIDTH-1:0] periph_oe
);
  logic [WIDTH-1:0] dir_q, mode_q, data_q, pin_lvl;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_lvl)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pin_lvl(pin_lvl), .bus_rdata(bus_rdata),
    .dir_q(dir_q), .mode_q(mode_q), .data_q(data_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_mux u_mux (
      .dir_b(dir_q[i]), .mode_b(mode_q[i]), .data_b(data_q[i]),
      .per_out(periph_out[i]), .per_oe(periph_oe[i]),
      .drv(pad_out[i]), .en(pad_oe[i])
    );
  end
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] periph_oe,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] mode_q,
  input logic [WIDTH-1:0] pin_lvl
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r9_released_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  a_r3_io_pushpull_on: assert property (@(posedge clk) disable iff (!rst_n)
    (~mode_q & ~dir_q & ~pad_oe) == '0);

  a_r7_sf_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ~periph_oe & pad_oe) == '0);

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> dir_q == $past(bus_wdata));

  a_r8_pin_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> pin_lvl == $past(pad_in, 2));
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .periph_oe(periph_oe), .dir_q(dir_q), .mode_q(mode_q), .pin_lvl(pin_lvl)
);

// File: tb/sim_gpio_port_ctl.sv
module sim_gpio_port_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pad_in = '0, pad_out, pad_oe;
  logic [7:0] periph_out = '0, periph_oe = '0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // scoreboard: kind 0 = pads (a=oe, b=out), kind 1 = read data (a)
  bit         q_kind [$];
  logic [7:0] q_a [$];
  logic [7:0] q_b [$];
  string      q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .periph_out(periph_out),
    .periph_oe(periph_oe)
  );

  initial begin : monitor
    forever begin
      wait (q_tag.size() > 0);
      vectors++;
      if (q_kind[0] == 1'b0) begin
        if (pad_oe !== q_a[0] || pad_out !== q_b[0]) begin
          errors++;
          $display("FAIL %s: oe=%h out=%h expected oe=%h out=%h",
                   q_tag[0], pad_oe, pad_out, q_a[0], q_b[0]);
        end
      end else if (bus_rdata !== q_a[0]) begin
        errors++;
        $display("FAIL %s: rdata=%h expected %h", q_tag[0], bus_rdata, q_a[0]);
      end
      void'(q_kind.pop_front()); void'(q_a.pop_front());
      void'(q_b.pop_front());    void'(q_tag.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic exp_pads(input string tag, input logic [7:0] oe, input logic [7:0] o);
    #1;
    q_kind.push_back(1'b0); q_a.push_back(oe); q_b.push_back(o); q_tag.push_back(tag);
    wait (q_tag.size() == 0);
  endtask

  task automatic exp_read(input string tag, input logic [1:0] a, input logic [7:0] d);
    bus_addr = a;
    #1;
    q_kind.push_back(1'b1); q_a.push_back(d); q_b.push_back('0); q_tag.push_back(tag);
    wait (q_tag.size() == 0);
  endtask

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_pads("R1 pads after reset", 8'h00, 8'h00);
    exp_read("R1 dir reset", 2'd0, 8'hFF);
    exp_read("R1 mode reset", 2'd1, 8'h00);
    exp_read("R1 data reset", 2'd2, 8'hFF);

    wr(2'd0, 8'h00); wr(2'd2, 8'hA5);
    exp_read("R2 dir readback", 2'd0, 8'h00);
    exp_read("R2 data readback", 2'd2, 8'hA5);
    exp_pads("R3 push-pull", 8'hFF, 8'hA5);

    wr(2'd0, 8'hFF); wr(2'd2, 8'h0F);
    exp_pads("R4 open-drain", 8'hF0, 8'h00);
    wr(2'd0, 8'hF0); wr(2'd2, 8'h3C);
    exp_pads("R3 R4 mixed", 8'hCF, 8'h0C);

    periph_out = 8'h5A; periph_oe = 8'hFF;
    wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
    exp_read("R2 mode readback", 2'd1, 8'hFF);
    exp_pads("R5 sf push-pull", 8'hFF, 8'h5A);
    wr(2'd2, 8'h00);
    exp_pads("R5 data ignored", 8'hFF, 8'h5A);

    wr(2'd0, 8'hFF);
    exp_pads("R6 sf open-drain", 8'hA5, 8'h00);

    periph_oe = 8'h0F;
    exp_pads("R7 R6 partial enable", 8'h05, 8'h00);
    periph_oe = 8'h00;
    exp_pads("R7 sf no enable", 8'h00, 8'h00);

    wr(2'd1, 8'hF0); wr(2'd0, 8'h00); wr(2'd2, 8'h3C); periph_oe = 8'hFF;
    exp_pads("R3 R5 mixed modes", 8'hFF, 8'h5C);

    @(negedge clk); pad_in = 8'hC3;
    @(negedge clk);
    exp_read("R8 one edge not yet", 2'd3, 8'h00);
    @(negedge clk);
    exp_read("R8 two edges", 2'd3, 8'hC3);

    wr(2'd3, 8'h55);
    exp_read("R8 pin write ignored", 2'd3, 8'hC3);
    exp_read("R8 dir untouched", 2'd0, 8'h00);
    exp_read("R8 mode untouched", 2'd1, 8'hF0);
    exp_read("R8 data untouched", 2'd2, 8'h3C);
    exp_pads("R8 pads untouched", 8'hFF, 8'h5C);

    wr(2'd1, 8'h00); wr(2'd0, 8'hFF); wr(2'd2, 8'hFF);
    @(negedge clk); pad_in = 8'h96;
    repeat (2) @(negedge clk);
    exp_pads("R9 all released", 8'h00, 8'h00);
    exp_read("R8 input config", 2'd3, 8'h96);
    done = 1'b1;
  end

  initial begin : finisher
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run incomplete, expected finish");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule